// File: doc/BRIEF.md
# Fail-Safe Clock Monitor

This block supervises a peripheral/device clock and, when that clock stops, moves the system onto the internal RC oscillator. A slow sample clock, taken from the always-running internal RC source, divides time into check windows. Each rising edge of the sample clock arms a check. A falling edge of the monitored clock that arrives afterwards disarms it. If the sample clock falls while the check is still armed, no monitored edge occurred in that window, and the block declares a clock failure.

On a failure the block raises a sticky interrupt flag. It also asserts a fallback-select output that forces the clock mux onto the internal oscillator, and it sends a single-cycle clear pulse to the watchdog. The fallback select is kept separate from the software-visible clock-source setting, which is not touched. It is released only when software writes a new clock selection. Both clock inputs are handled as data. They pass through synchronizers into a fast reference clock domain, so every state element runs on that one clock. The sample clock generator and the clock mux lie outside this block.

Top module: `fscm_top`

## Requirements
- R1: While reset is asserted, failFlag, fallbackSel and wdtClearPulse are all low.
- R2: A rising edge of smpClk arms the check. A falling edge of monClk disarms it. A falling edge of smpClk while the check is still armed is a detected failure. If a monClk fall lands in the same cycle as the smpClk edge, it counts as seen.
- R3: While monClk gives at least one falling edge during every high phase of smpClk, no failure is detected and all three outputs stay low.
- R4: A detected failure sets failFlag. failFlag stays set until a one-cycle flagClear, and a detection in the same cycle as flagClear leaves it set.
- R5: A detected failure sets fallbackSel. fallbackSel stays set until clkSelWrite, and a detection in the same cycle wins over the write. If monClk is still dead after the write, a new failure is detected.
- R6: Each detected failure produces exactly one wdtClearPulse, high for one reference cycle. The pulse appears on the same edge on which failFlag and fallbackSel become set.
- R7: While fallbackSel is high, further missed windows are not detected: there is no new pulse and a cleared failFlag stays clear.
- R8: While monEnable is low, the check is held disarmed and no failure is ever detected.
- R9: intOscRun is high whenever monEnable or fallbackSel is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkRef | input | 1 | Fast reference clock for all state |
| rstN | input | 1 | Asynchronous active-low reset |
| monClk | input | 1 | Monitored device clock, sampled as data |
| smpClk | input | 1 | Slow sample clock from the internal RC, sampled as data |
| monEnable | input | 1 | Configuration enable of the monitor |
| flagClear | input | 1 | One-cycle software clear of the fail flag |
| clkSelWrite | input | 1 | One-cycle strobe: software wrote a new clock selection |
| failFlag | output | 1 | Sticky oscillator-fail interrupt flag |
| fallbackSel | output | 1 | Forces the clock mux onto the internal oscillator |
| wdtClearPulse | output | 1 | One-cycle watchdog reset pulse per failure |
| intOscRun | output | 1 | Run request for the internal RC oscillator |

## Verification
The bench builds the block with SYNC_STAGES = 3 instead of the default 2. This lengthens the path from a pin change to a decision, and it shows that the checks do not depend on a fixed latency. The monitored clock toggles every 4 reference cycles and the sample clock every 40. Each sample window therefore holds several monitored falls, and stopping the monitored clock produces a failure within about two windows. This setup reaches the main cases: repeated missed windows while the fallback is held, a selection write while the clock is still dead, recovery, and a disabled monitor facing a dead clock.

// File: rtl/fscm_pkg.sv
package fscm_pkg;

  localparam int LANE_MON  = 0;
  localparam int LANE_SMP  = 1;
  localparam int NUM_LANES = 2;

  // Edge events seen in the reference domain
  typedef struct packed {
    logic monFall;
    logic smpRise;
    logic smpFall;
  } edgeEvt_t;

  // Strobes from the control to the datapath registers
  typedef struct packed {
    logic armSet;
    logic armClr;
    logic failSet;
    logic flagClr;
    logic selClr;
    logic wdtFire;
  } ctlStrobe_t;

endpackage

// File: rtl/fscm_datapath.sv
module fscm_datapath
  import fscm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clkRef,
  input  logic       rstN,
  input  logic       monClk,
  input  logic       smpClk,
  input  ctlStrobe_t strb,
  output edgeEvt_t   evt,
  output logic       armed,
  output logic       failFlag,
  output logic       fallbackSel,
  output logic       wdtPulse
);

  logic [NUM_LANES-1:0] rawIn;
  logic [NUM_LANES-1:0] syncOut;
  logic [NUM_LANES-1:0] prevOut;

  assign rawIn[LANE_MON] = monClk;
  assign rawIn[LANE_SMP] = smpClk;

  // One synchronizer chain plus a history flop per sampled clock
  for (genvar lane = 0; lane < NUM_LANES; lane++) begin : gLane
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clkRef or negedge rstN) begin
      if (!rstN) begin
        chain         <= '0;
        prevOut[lane] <= 1'b0;
      end else begin
        chain         <= {chain[SYNC_STAGES-2:0], rawIn[lane]};
        prevOut[lane] <= chain[SYNC_STAGES-1];
      end
    end
    assign syncOut[lane] = chain[SYNC_STAGES-1];
  end

  assign evt.monFall = prevOut[LANE_MON] & ~syncOut[LANE_MON];
  assign evt.smpRise = ~prevOut[LANE_SMP] & syncOut[LANE_SMP];
  assign evt.smpFall = prevOut[LANE_SMP] & ~syncOut[LANE_SMP];

  logic armedQ, failFlagQ, fallbackQ, wdtPulseQ;

  always_ff @(posedge clkRef or negedge rstN) begin
    if (!rstN) begin
      armedQ    <= 1'b0;
      failFlagQ <= 1'b0;
      fallbackQ <= 1'b0;
      wdtPulseQ <= 1'b0;
    end else begin
      if (strb.armClr)      armedQ <= 1'b0;
      else if (strb.armSet) armedQ <= 1'b1;

      if (strb.failSet)      failFlagQ <= 1'b1;
      else if (strb.flagClr) failFlagQ <= 1'b0;

      if (strb.failSet)     fallbackQ <= 1'b1;
      else if (strb.selClr) fallbackQ <= 1'b0;

      wdtPulseQ <= strb.wdtFire;
    end
  end

  assign armed       = armedQ;
  assign failFlag    = failFlagQ;
  assign fallbackSel = fallbackQ;
  assign wdtPulse    = wdtPulseQ;

  AST_ARM_DROPS_ON_EDGE: assert property (@(posedge clkRef) disable iff (!rstN)
    evt.monFall |=> !armedQ); // R2
  AST_FLAG_STICKY: assert property (@(posedge clkRef) disable iff (!rstN)
    failFlagQ && !strb.flagClr |=> failFlagQ); // R4
  AST_SEL_HOLDS: assert property (@(posedge clkRef) disable iff (!rstN)
    fallbackQ && !strb.selClr |=> fallbackQ); // R5
  AST_PULSE_SINGLE: assert property (@(posedge clkRef) disable iff (!rstN)
    wdtPulseQ |=> !wdtPulseQ); // R6
  AST_PULSE_WITH_FLAGS: assert property (@(posedge clkRef) disable iff (!rstN)
    wdtPulseQ |-> failFlagQ && fallbackQ); // R6
  AST_NO_REPEAT: assert property (@(posedge clkRef) disable iff (!rstN)
    fallbackQ && !strb.selClr |=> !wdtPulseQ); // R7

endmodule

// File: rtl/fscm_control.sv
module fscm_control
  import fscm_pkg::*;
(
  input  logic       enable,
  input  logic       flagClear,
  input  logic       clkSelWrite,
  input  edgeEvt_t   evt,
  input  logic       armed,
  input  logic       fallbackSel,
  output ctlStrobe_t strb
);

  logic detect;

  // A monitored fall in the deciding cycle still counts as a live clock
  assign detect = enable & evt.smpFall & armed & ~evt.monFall & ~fallbackSel;

  always_comb begin
    strb         = '0;
    strb.armClr  = ~enable | evt.monFall;
    strb.armSet  = enable & evt.smpRise;
    strb.failSet = detect;
    strb.wdtFire = detect;
    strb.flagClr = flagClear;
    strb.selClr  = clkSelWrite;
  end

endmodule

// File: rtl/fscm_top.sv
module fscm_top
  import fscm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clkRef,
  input  logic rstN,
  input  logic monClk,
  input  logic smpClk,
  input  logic monEnable,
  input  logic flagClear,
  input  logic clkSelWrite,
  output logic failFlag,
  output logic fallbackSel,
  output logic wdtClearPulse,
  output logic intOscRun
);

  edgeEvt_t   evtW;
  ctlStrobe_t strbW;
  logic       armedW;

  fscm_datapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clkRef      (clkRef),
    .rstN        (rstN),
    .monClk      (monClk),
    .smpClk      (smpClk),
    .strb        (strbW),
    .evt         (evtW),
    .armed       (armedW),
    .failFlag    (failFlag),
    .fallbackSel (fallbackSel),
    .wdtPulse    (wdtClearPulse)
  );

  fscm_control ctl_i (
    .enable      (monEnable),
    .flagClear   (flagClear),
    .clkSelWrite (clkSelWrite),
    .evt         (evtW),
    .armed       (armedW),
    .fallbackSel (fallbackSel),
    .strb        (strbW)
  );

  assign intOscRun = monEnable | fallbackSel;

  AST_IDLE_WHEN_OFF: assert property (@(posedge clkRef) disable iff (!rstN)
    !monEnable |=> !armedW); // R8

endmodule

// File: tb/fscm_top_tb_top.sv
`timescale 1ns/1ps
module fscm_top_tb_top;

  localparam int MON_HALF = 4;
  localparam int SMP_HALF = 40;

  logic clkRef = 1'b0;
  logic rstN = 1'b0;
  logic monClk = 1'b0;
  logic smpClk = 1'b0;
  logic monEnable = 1'b1;
  logic flagClear = 1'b0;
  logic clkSelWrite = 1'b0;
  logic failFlag, fallbackSel, wdtClearPulse, intOscRun;
  logic monRun = 1'b0;
  logic done = 1'b0;

  int vectors = 0;
  int fails = 0;
  int episodes = 0;
  int pushed = 0;
  int expQ[$];

  always #2 clkRef = ~clkRef;

  fscm_top #(.SYNC_STAGES(3)) dut_i (
    .clkRef(clkRef), .rstN(rstN), .monClk(monClk), .smpClk(smpClk),
    .monEnable(monEnable), .flagClear(flagClear), .clkSelWrite(clkSelWrite),
    .failFlag(failFlag), .fallbackSel(fallbackSel),
    .wdtClearPulse(wdtClearPulse), .intOscRun(intOscRun)
  );

  initial forever begin
    repeat (MON_HALF) @(negedge clkRef);
    if (monRun) monClk = ~monClk;
  end

  initial forever begin
    repeat (SMP_HALF) @(negedge clkRef);
    smpClk = ~smpClk;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic expectFailure();
    pushed++;
    expQ.push_back(pushed);
  endtask

  task automatic chkDrained(input string req);
    vectors++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL %s: actual %0d pending pulses expected 0", req, expQ.size());
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clkRef);
  endtask

  // Monitor: pops one expected failure per watchdog pulse
  initial begin
    logic prevPulse;
    prevPulse = 1'b0;
    forever begin
      @(negedge clkRef);
      if (rstN && wdtClearPulse) begin
        vectors++;
        if (prevPulse) begin
          fails++;
          $display("FAIL R6: actual pulse width >1 expected 1");
        end else if (expQ.size() == 0) begin
          fails++;
          $display("FAIL R7: actual unexpected pulse expected none");
        end else begin
          int item;
          item = expQ.pop_front();
          episodes++;
          if (item != episodes) begin
            fails++;
            $display("FAIL R6: actual episode %0d expected %0d", episodes, item);
          end
        end
        chk("R6 flag with pulse", failFlag, 1'b1);
        chk("R6 select with pulse", fallbackSel, 1'b1);
      end
      prevPulse = wdtClearPulse;
    end
  end

  initial begin
    repeat (200000) @(posedge clkRef);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    cyc(5);
    chk("R1 flag in reset", failFlag, 1'b0);
    chk("R1 select in reset", fallbackSel, 1'b0);
    chk("R1 pulse in reset", wdtClearPulse, 1'b0);
    chk("R9 run with enable", intOscRun, 1'b1);
    rstN = 1'b1;
    monRun = 1'b1;
    cyc(400);
    chk("R3 flag with live clock", failFlag, 1'b0);
    chk("R3 select with live clock", fallbackSel, 1'b0);

    // R2: stop the monitored clock
    monRun = 1'b0;
    expectFailure();
    cyc(300);
    chkDrained("R2 failure pulse");
    chk("R4 flag set", failFlag, 1'b1);
    chk("R5 select set", fallbackSel, 1'b1);
    cyc(400);
    chk("R4 flag sticky", failFlag, 1'b1);

    flagClear = 1'b1; cyc(1); flagClear = 1'b0; cyc(1);
    chk("R4 flag cleared", failFlag, 1'b0);
    chk("R5 select kept after flag clear", fallbackSel, 1'b1);
    cyc(300);
    chk("R7 no re-detect in fallback", failFlag, 1'b0);

    // R5: new selection while clock still dead
    clkSelWrite = 1'b1; expectFailure(); cyc(1); clkSelWrite = 1'b0; cyc(1);
    chk("R5 select released", fallbackSel, 1'b0);
    cyc(300);
    chkDrained("R5 re-detect pulse");
    chk("R5 re-detect flag", failFlag, 1'b1);
    chk("R5 re-detect select", fallbackSel, 1'b1);

    // Recovery
    monRun = 1'b1;
    flagClear = 1'b1; clkSelWrite = 1'b1; cyc(1);
    flagClear = 1'b0; clkSelWrite = 1'b0;
    cyc(300);
    chk("R3 flag after recovery", failFlag, 1'b0);
    chk("R3 select after recovery", fallbackSel, 1'b0);

    // R8: disabled monitor with a dead clock
    monEnable = 1'b0; monRun = 1'b0; cyc(2);
    chk("R9 run low when idle", intOscRun, 1'b0);
    cyc(400);
    chk("R8 flag while disabled", failFlag, 1'b0);
    chk("R8 select while disabled", fallbackSel, 1'b0);

    monEnable = 1'b1; expectFailure();
    cyc(300);
    chkDrained("R2 detect after enable");
    chk("R2 flag after enable", failFlag, 1'b1);
    monEnable = 1'b0; cyc(2);
    chk("R9 run held by fallback", intOscRun, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule